// File: doc/BRIEF.md
# Shared-Port Up/Down Binary Counter

This block is a synchronous binary counter that can count up or count down and that uses one shared data port both to take in a parallel load value and to present its count. A two-bit mode input chooses one of four operations: load, count up, count down or hold. An active-low count enable gates the two counting modes. An active-low output enable decides whether the counter drives the shared port. Every register change happens on the rising clock edge, and there is no reset. The owner brings the register to a known value with a load.

The shared port is split into three signals: an input data vector, an output data vector and a drive-enable flag. A pad ring or a bus wrapper joins them into a tri-state line. A load is only valid while the output enable is inactive, because the surrounding logic then owns the line.

An active-low terminal-count output is combinational from the mode, the count enable and the registered value. Wider counters are built by chaining stages: each later stage takes the earlier stage's terminal count as its count enable.

Top module: `bidir_updown_counter`

## Requirements
- R1: With mode 2'b00 (load), the register takes `bus_in` at the rising clock edge, whether `cen_n` is high or low.
- R2: With mode 2'b01 (up) and `cen_n` low, the register goes up by one on each rising edge, and all ones wraps to all zeros.
- R3: With mode 2'b10 (down) and `cen_n` low, the register goes down by one on each rising edge, and all zeros wraps to all ones.
- R4: With mode 2'b11 (hold), the register keeps its value whatever the level of `cen_n`.
- R5: In mode up or mode down with `cen_n` high, the register keeps its value.
- R6: While `oe_n` is low, `bus_drive` is 1 and `bus_out` equals the register. While `oe_n` is high, `bus_drive` is 0 and `bus_out` is all zeros.
- R7: `tc_n` is 0 exactly when `cen_n` is low and either the mode is up with the register all ones or the mode is down with the register all zeros. It is 1 in load mode and in hold mode.
- R8: `tc_n` follows changes on `mode` and `cen_n` within the same clock cycle, with no clock edge needed.
- R9: Two stages, with the upper stage's `cen_n` tied to the lower stage's `tc_n`, count as one double-width counter up and down across the boundary between the two stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all register updates on the rising edge |
| mode | input | 2 | Operation: 00 load, 01 up, 10 down, 11 hold |
| cen_n | input | 1 | Count enable, active low; gates up and down only |
| oe_n | input | 1 | Output enable for the shared port, active low |
| bus_in | input | WIDTH | Value seen on the shared port, used as load data |
| bus_out | output | WIDTH | Register value presented to the shared port |
| bus_drive | output | 1 | High when the counter drives the shared port |
| tc_n | output | 1 | Terminal count, active low, look-ahead for chaining |

## Verification
The bench aims at both wrap points and at the terminal count there. A design that saturated instead of wrapping, or that decoded the terminal count from the wrong end of the range, would show a wrong value after the wrap or a wrong `tc_n` level. It changes `cen_n` and `mode` between clock edges with no edge following, which catches a `tc_n` that was built from registered copies of those inputs. It loads while `cen_n` is high and holds while `cen_n` is low, which catches a load gated by the enable or a hold that counts anyway. A two-stage chain that counts across the byte boundary in both directions finds a terminal count that fails to carry or borrow; every random load is also checked to confirm the output enable was high, so no cycle has both the counter and the bench driving the port.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

   // Two-bit operation code presented on the mode input
   typedef enum logic [1:0] {
      MODE_LOAD = 2'b00,
      MODE_UP   = 2'b01,
      MODE_DOWN = 2'b10,
      MODE_HOLD = 2'b11
   } ctr_mode_e;

   // Decoded controls handed from the decoder to the datapath
   typedef struct packed {
      logic load;
      logic step_up;
      logic step_dn;
      logic sel_up;
      logic sel_dn;
   } ctr_ctl_t;

endpackage

// File: rtl/ctr_mode_dec.sv
module ctr_mode_dec
   import ctr_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       cen_n,
   output ctr_ctl_t   ctl
);

   ctr_mode_e op;

   always_comb begin
      op          = ctr_mode_e'(mode);
      ctl         = '0;
      ctl.load    = (op == MODE_LOAD);
      ctl.sel_up  = (op == MODE_UP);
      ctl.sel_dn  = (op == MODE_DOWN);
      ctl.step_up = ctl.sel_up & ~cen_n;
      ctl.step_dn = ctl.sel_dn & ~cen_n;
   end

endmodule

// File: rtl/ctr_step.sv
module ctr_step #(
   parameter int WIDTH       = 8,
   parameter bit RIPPLE_STEP = 1'b0
) (
   input  logic [WIDTH-1:0] cur,
   input  logic             step_up,
   input  logic             step_dn,
   output logic [WIDTH-1:0] nxt
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   if (WIDTH < 2) begin : g_width_chk
      $error("ctr_step: WIDTH must be at least 2");
   end

   if (RIPPLE_STEP) begin : g_toggle
      // toggle chain: a bit flips when every lower bit is at the
      // carry level for up (ones) or the borrow level for down (zeros)
      logic [WIDTH:0] tgl;
      assign tgl[0] = step_up | step_dn;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign tgl[i+1] = tgl[i] & (step_up ? cur[i] : ~cur[i]);
         assign nxt[i]   = cur[i] ^ tgl[i];
      end
   end else begin : g_adder
      always_comb begin
         if (step_up)      nxt = cur + ONE;
         else if (step_dn) nxt = cur - ONE;
         else              nxt = cur;
      end
   end

endmodule

// File: rtl/ctr_term.sv
module ctr_term #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] value,
   input  logic             sel_up,
   input  logic             sel_dn,
   input  logic             cen_n,
   output logic             tc_n
);

   logic at_top;
   logic at_bottom;

   assign at_top    = &value;
   assign at_bottom = ~|value;
   assign tc_n      = ~(~cen_n & ((sel_up & at_top) | (sel_dn & at_bottom)));

endmodule

// File: rtl/bidir_updown_counter.sv
module bidir_updown_counter
   import ctr_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter bit RIPPLE_STEP = 1'b0
) (
   input  logic             clk,
   input  logic [1:0]       mode,
   input  logic             cen_n,
   input  logic             oe_n,
   input  logic [WIDTH-1:0] bus_in,
   output logic [WIDTH-1:0] bus_out,
   output logic             bus_drive,
   output logic             tc_n
);

   if (WIDTH < 2 || WIDTH > 64) begin : g_width_chk
      $error("bidir_updown_counter: WIDTH out of range 2..64");
   end

   ctr_ctl_t         ctl;
   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_step;
   logic [WIDTH-1:0] cnt_d;

   ctr_mode_dec u_dec (
      .mode  (mode),
      .cen_n (cen_n),
      .ctl   (ctl)
   );

   ctr_step #(
      .WIDTH       (WIDTH),
      .RIPPLE_STEP (RIPPLE_STEP)
   ) u_step (
      .cur     (cnt_q),
      .step_up (ctl.step_up),
      .step_dn (ctl.step_dn),
      .nxt     (cnt_step)
   );

   ctr_term #(
      .WIDTH (WIDTH)
   ) u_term (
      .value  (cnt_q),
      .sel_up (ctl.sel_up),
      .sel_dn (ctl.sel_dn),
      .cen_n  (cen_n),
      .tc_n   (tc_n)
   );

   assign cnt_d = ctl.load ? bus_in : cnt_step;

   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

   assign bus_drive = ~oe_n;
   assign bus_out   = bus_drive ? cnt_q : '0;

endmodule

// File: rtl/bidir_updown_counter_chk.sv
module bidir_updown_counter_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic [1:0]       mode,
   input logic             cen_n,
   input logic             oe_n,
   input logic [WIDTH-1:0] bus_in,
   input logic [WIDTH-1:0] bus_out,
   input logic             bus_drive,
   input logic             tc_n,
   input logic [WIDTH-1:0] cnt_q
);

   logic armed = 1'b0;

   always_ff @(posedge clk) begin
      armed <= 1'b1;
   end

   a_r1_load_takes_bus: assert property (@(posedge clk) disable iff (!armed)
      (mode == 2'b00) |=> (cnt_q == $past(bus_in)));

   a_r2_count_up: assert property (@(posedge clk) disable iff (!armed)
      (mode == 2'b01 && !cen_n) |=> (cnt_q == WIDTH'($past(cnt_q) + 1'b1)));

   a_r3_count_down: assert property (@(posedge clk) disable iff (!armed)
      (mode == 2'b10 && !cen_n) |=> (cnt_q == WIDTH'($past(cnt_q) - 1'b1)));

   a_r4_hold_mode: assert property (@(posedge clk) disable iff (!armed)
      (mode == 2'b11) |=> $stable(cnt_q));

   a_r5_enable_gates: assert property (@(posedge clk) disable iff (!armed)
      ((mode == 2'b01 || mode == 2'b10) && cen_n) |=> $stable(cnt_q));

   a_r6_port_drive: assert property (@(posedge clk) disable iff (!armed)
      !oe_n |-> (bus_drive && bus_out == cnt_q));

   a_r6_port_quiet: assert property (@(posedge clk) disable iff (!armed)
      oe_n |-> (!bus_drive && bus_out == '0));

   a_r7_tc_idle_modes: assert property (@(posedge clk) disable iff (!armed)
      (mode == 2'b00 || mode == 2'b11 || cen_n) |-> tc_n);

   a_r7_tc_low_at_end: assert property (@(posedge clk) disable iff (!armed)
      (!cen_n && ((mode == 2'b01 && &cnt_q) || (mode == 2'b10 && ~|cnt_q))) |-> !tc_n);

endmodule

bind bidir_updown_counter bidir_updown_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .mode      (mode),
   .cen_n     (cen_n),
   .oe_n      (oe_n),
   .bus_in    (bus_in),
   .bus_out   (bus_out),
   .bus_drive (bus_drive),
   .tc_n      (tc_n),
   .cnt_q     (cnt_q)
);

// File: tb/bidir_updown_counter_test.sv
module bidir_updown_counter_test;

   logic       clk = 1'b0;
   logic [1:0] mode = 2'b11;
   logic       cen_n = 1'b1;
   logic       oe_n = 1'b1;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       drv;
   logic       tc_n;

   logic [1:0] c_mode = 2'b11;
   logic       c_cen_n = 1'b1;
   logic       c_oe_n = 1'b1;
   logic [15:0] c_din = 16'h0;
   logic [7:0] c_lo_out, c_hi_out;
   logic       c_lo_drv, c_hi_drv, c_lo_tc, c_hi_tc;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;
   logic [7:0] model = 8'h00;

   always #4 clk = ~clk;

   bidir_updown_counter #(.WIDTH(8)) uut (
      .clk(clk), .mode(mode), .cen_n(cen_n), .oe_n(oe_n), .bus_in(din),
      .bus_out(dout), .bus_drive(drv), .tc_n(tc_n));

   bidir_updown_counter #(.WIDTH(8), .RIPPLE_STEP(1'b1)) cas_lo (
      .clk(clk), .mode(c_mode), .cen_n(c_cen_n), .oe_n(c_oe_n), .bus_in(c_din[7:0]),
      .bus_out(c_lo_out), .bus_drive(c_lo_drv), .tc_n(c_lo_tc));

   bidir_updown_counter #(.WIDTH(8), .RIPPLE_STEP(1'b1)) cas_hi (
      .clk(clk), .mode(c_mode), .cen_n(c_lo_tc), .oe_n(c_oe_n), .bus_in(c_din[15:8]),
      .bus_out(c_hi_out), .bus_drive(c_hi_drv), .tc_n(c_hi_tc));

   function automatic logic exp_tc(logic [1:0] m, logic c, logic [7:0] v);
      if (!c && ((m == 2'b01 && v == 8'hFF) || (m == 2'b10 && v == 8'h00))) return 1'b0;
      return 1'b1;
   endfunction

   function automatic logic [7:0] exp_next(logic [1:0] m, logic c, logic [7:0] v, logic [7:0] d);
      case (m)
         2'b00:   return d;
         2'b01:   return c ? v : v + 8'd1;
         2'b10:   return c ? v : v - 8'd1;
         default: return v;
      endcase
   endfunction

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one cycle of the single counter: drive at falling edge, check port and
   // terminal count before the rising edge, then advance the model
   task automatic step(logic [1:0] m, logic c, logic o, logic [7:0] d, string req);
      @(negedge clk);
      mode = m; cen_n = c; oe_n = o; din = d;
      #1;
      if (m == 2'b00) check({"R1 no contention ", req}, {15'd0, oe_n}, 16'd1);
      if (!o) begin
         check({"R6 drive ", req}, {7'd0, drv, dout}, {7'd0, 1'b1, model});
      end else begin
         check({"R6 quiet ", req}, {7'd0, drv, dout}, 16'd0);
      end
      check({"R7 tc ", req}, {15'd0, tc_n}, {15'd0, exp_tc(m, c, model)});
      @(posedge clk);
      model = exp_next(m, c, model, d);
   endtask

   task automatic look(string req);
      step(2'b11, 1'b1, 1'b0, 8'h00, req);
   endtask

   task automatic chain(logic [1:0] m, logic c, logic [15:0] d);
      @(negedge clk);
      c_mode = m; c_cen_n = c; c_din = d;
      c_oe_n = (m == 2'b00);
      @(posedge clk);
   endtask

   initial begin
      void'($urandom(32'd2718));
      // bring the register to a known value
      step(2'b00, 1'b1, 1'b1, 8'hFE, "R1 load cen high");
      look("R1 after load");
      check("R1 load value", {8'd0, dout}, 16'h00FE);

      step(2'b01, 1'b0, 1'b0, 8'h00, "R2 up to FF");
      step(2'b01, 1'b0, 1'b0, 8'h00, "R7 up at FF");
      look("R2 wrap");
      check("R2 wrap FF to 00", {8'd0, dout}, 16'h0000);

      step(2'b10, 1'b0, 1'b0, 8'h00, "R7 down at 00");
      look("R3 wrap");
      check("R3 wrap 00 to FF", {8'd0, dout}, 16'h00FF);

      step(2'b11, 1'b0, 1'b0, 8'h00, "R4 hold cen low");
      step(2'b01, 1'b1, 1'b0, 8'h00, "R5 up gated");
      step(2'b10, 1'b1, 1'b0, 8'h00, "R5 down gated");
      look("R4 R5 value");
      check("R4 R5 kept", {8'd0, dout}, 16'h00FF);

      step(2'b00, 1'b0, 1'b1, 8'h00, "R1 load cen low");
      step(2'b11, 1'b0, 1'b1, 8'h00, "R7 hold at 00");

      // R8: tc_n reacts to cen_n and mode with no edge in between
      @(negedge clk);
      mode = 2'b10; cen_n = 1'b1; oe_n = 1'b0;
      #1 check("R8 tc high cen off", {15'd0, tc_n}, 16'd1);
      cen_n = 1'b0;
      #1 check("R8 tc low cen on", {15'd0, tc_n}, 16'd0);
      mode = 2'b01;
      #1 check("R8 tc high mode up", {15'd0, tc_n}, 16'd1);
      mode = 2'b00;
      #1 check("R8 tc high mode load", {15'd0, tc_n}, 16'd1);
      mode = 2'b11; cen_n = 1'b1; oe_n = 1'b1;

      // random traffic; loads always with the output enable high
      for (int i = 0; i < 400; i++) begin
         logic [1:0] m;
         logic c, o;
         logic [7:0] d;
         m = 2'($urandom);
         c = 1'($urandom);
         o = 1'($urandom);
         d = 8'($urandom);
         if ((i % 37) == 0) begin
            m = 2'b00; d = (i[0]) ? 8'hFF : 8'h00;
         end
         if (m == 2'b00) o = 1'b1;
         step(m, c, o, d, "R2 R3 R4 R5 random");
      end

      // R9: two chained stages as one 16-bit counter
      chain(2'b00, 1'b1, 16'h00FD);
      for (int k = 0; k < 6; k++) chain(2'b01, 1'b0, 16'h0);
      chain(2'b11, 1'b1, 16'h0);
      #1 check("R9 chain up across byte", {c_hi_out, c_lo_out}, 16'h0103);
      chain(2'b00, 1'b1, 16'h0102);
      for (int k = 0; k < 5; k++) chain(2'b10, 1'b0, 16'h0);
      chain(2'b11, 1'b1, 16'h0);
      #1 check("R9 chain down across byte", {c_hi_out, c_lo_out}, 16'h00FD);
      chain(2'b00, 1'b1, 16'hFFFF);
      chain(2'b01, 1'b0, 16'h0);
      #1 check("R9 chain full wrap", {c_hi_out, c_lo_out}, 16'h0000);
      chain(2'b01, 1'b1, 16'h0);
      #1 check("R9 chain gated", {c_hi_out, c_lo_out}, 16'h0000);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

endmodule